// File: doc/BRIEF.md
# Segmented Dictionary Scan Expander

This block feeds a long scan chain from a short compressed one. It treats the long chain as a run of consecutive segments. For each segment it collects a small code from the compressed chain, looks that code up in the segment's own dictionary and shifts the stored pattern into the long chain, one bit per clock. Every segment has its own code width and output length, so a few code bits can stand for a long stretch of scan data.

Don't-care positions were already filled with zero when the dictionaries were built, so every stored pattern holds plain 0/1 data. Before a test pattern starts, software writes the dictionaries through a configuration port. Each segment gets a header (code width, output length and an end-of-pattern mark) followed by its entries. Decoding then runs segment by segment, from segment 0 up to the first segment that is marked as the end. That final segment raises a one-cycle done pulse, and the block returns to segment 0 to wait for the next test pattern.

The compressed input is a valid/ready stream. A bit moves only in a cycle where both `code_valid` and `code_ready` are high. `code_ready` goes low for the whole time a segment is being emitted. A source may hold `code_valid` high during that time without losing the bit. The scan output has no back-pressure: while `scan_en` is high, `scan_out` carries a valid chain bit in every cycle.

Top module: `seg_scan_expander`

## Requirements
- R1: After reset `code_ready` is 1, and `scan_en`, `pattern_done` and `code_err` are 0.
- R2: A segment's code is collected MSB first, over as many accepted bits as that segment's header code width (1 to 5). `code_ready` is 1 during collection.
- R3: In the cycle after the last code bit is accepted, `scan_en` rises. It stays high for the segment's length. `scan_out` carries stored pattern bit 0 first, then bit 1, and so on.
- R4: Each segment uses its own header: code width, and an output length from 1 to 256. The bits of a stored entry beyond that length are never emitted.
- R5: Segments are decoded strictly in index order. No code bit is accepted while a segment is emitting, and `scan_en` is 0 while a code is being collected.
- R6: If a code selects an entry that is not loaded, the segment emits zeros for its full length. It also sets `code_err`, which stays set until reset.
- R7: A segment ends the pattern if its header end mark is 1, or if it is the highest segment. When it finishes, `pattern_done` is 1 for exactly the one cycle after its final output bit, and decoding restarts at segment 0.
- R8: Configuration writes (`cfg_kind` 0 = header, 1 = entry) are ignored while a pattern is in progress. A pattern is in progress from its first accepted code bit until `pattern_done`.
- R9: A header write marks every entry of that segment as not loaded. An entry write with `cfg_idx` stores `cfg_pattern` and marks that entry as loaded.
- R10: While `code_ready` is 0, a held `code_valid` consumes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = header write, 1 = entry write |
| cfg_seg | input | SEG_W | Target segment index |
| cfg_code_w | input | CWF_W | Header: code width, 1 to MAX_CODE_W |
| cfg_len | input | LEN_W | Header: output length, 1 to MAX_LEN |
| cfg_last | input | 1 | Header: segment ends the pattern |
| cfg_idx | input | MAX_CODE_W | Entry: code value of the entry |
| cfg_pattern | input | MAX_LEN | Entry: pattern, bit 0 emitted first |
| code_valid | input | 1 | Compressed code bit is valid |
| code_bit | input | 1 | Compressed code bit |
| code_ready | output | 1 | Block accepts a code bit |
| scan_out | output | 1 | Bit into the long scan chain |
| scan_en | output | 1 | Scan shift strobe, scan_out is valid |
| pattern_done | output | 1 | One-cycle pulse after the final segment |
| code_err | output | 1 | Sticky flag: a code hit an unloaded entry |

## Verification
The hardest situations to reach from the ports are the back-pressure case and the ignored writes. In the first, `code_valid` is held high across a whole emission. In the second, configuration writes arrive between two segments of a pattern that is already in progress. Neither shows up unless a later segment is checked bit by bit. The stimulus sweeps every code of a 3-bit segment through a chain of segments with 2-bit and 1-bit codes, including a segment of length 256. In one pass it holds valid high during emission, and in another it issues header and entry writes halfway through a pattern. In both cases the following segment's output must match the original dictionary. A later header rewrite leaves some entries unloaded, which drives the zero-fill and error path.

// File: rtl/seg_exp_pkg.sv
package seg_exp_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } seg_state_t;

  typedef enum logic {
    CFG_HEADER = 1'b0,
    CFG_ENTRY  = 1'b1
  } cfg_kind_t;
endpackage

// File: rtl/seg_exp_dict.sv
module seg_exp_dict #(
  parameter int NUM_SEG    = 4,
  parameter int MAX_CODE_W = 5,
  parameter int MAX_LEN    = 256,
  parameter int SEG_W      = 2,
  parameter int CWF_W      = 3,
  parameter int LEN_W      = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hdr,
  input  logic                  wr_ent,
  input  logic [SEG_W-1:0]      wr_seg,
  input  logic [CWF_W-1:0]      wr_code_w,
  input  logic [LEN_W-1:0]      wr_len,
  input  logic                  wr_last,
  input  logic [MAX_CODE_W-1:0] wr_idx,
  input  logic [MAX_LEN-1:0]    wr_pat,
  input  logic [SEG_W-1:0]      rd_seg,
  input  logic [MAX_CODE_W-1:0] rd_idx,
  output logic [MAX_LEN-1:0]    rd_pat,
  output logic                  rd_hit,
  output logic [CWF_W-1:0]      cur_code_w,
  output logic [LEN_W-1:0]      cur_len,
  output logic                  cur_last
);
  localparam int ENTRIES = 1 << MAX_CODE_W;

  logic [MAX_LEN-1:0] seg_pat  [NUM_SEG];
  logic               seg_hit  [NUM_SEG];
  logic [CWF_W-1:0]   seg_cw   [NUM_SEG];
  logic [LEN_W-1:0]   seg_len  [NUM_SEG];
  logic               seg_last [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam bit IS_TOP = (g == NUM_SEG - 1);
    logic [ENTRIES-1:0] loaded;
    logic [MAX_LEN-1:0] store [ENTRIES];
    logic [CWF_W-1:0]   cw_q;
    logic [LEN_W-1:0]   len_q;
    logic               last_q;
    logic               hit_me;

    assign hit_me = (wr_seg == SEG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loaded <= '0;
        cw_q   <= CWF_W'(1);
        len_q  <= LEN_W'(1);
        last_q <= IS_TOP;
      end else if (wr_hdr && hit_me) begin
        loaded <= '0;
        cw_q   <= wr_code_w;
        len_q  <= wr_len;
        last_q <= wr_last | IS_TOP;
      end else if (wr_ent && hit_me) begin
        loaded[wr_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_ent && hit_me) store[wr_idx] <= wr_pat;
    end

    assign seg_pat[g]  = store[rd_idx];
    assign seg_hit[g]  = loaded[rd_idx];
    assign seg_cw[g]   = cw_q;
    assign seg_len[g]  = len_q;
    assign seg_last[g] = last_q;
  end

  assign rd_pat     = seg_pat[rd_seg];
  assign rd_hit     = seg_hit[rd_seg];
  assign cur_code_w = seg_cw[rd_seg];
  assign cur_len    = seg_len[rd_seg];
  assign cur_last   = seg_last[rd_seg];
endmodule

// File: rtl/seg_exp_ctrl.sv
module seg_exp_ctrl
  import seg_exp_pkg::*;
#(
  parameter int MAX_CODE_W = 5,
  parameter int SEG_W      = 2,
  parameter int CWF_W      = 3,
  parameter int LEN_W      = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  code_valid,
  input  logic                  code_bit,
  input  logic [CWF_W-1:0]      cur_code_w,
  input  logic [LEN_W-1:0]      cur_len,
  input  logic                  cur_last,
  input  logic                  rd_hit,
  output logic                  code_ready,
  output logic [SEG_W-1:0]      rd_seg,
  output logic [MAX_CODE_W-1:0] rd_idx,
  output logic                  load,
  output logic                  emitting,
  output logic                  active,
  output logic                  pattern_done,
  output logic                  code_err
);
  seg_state_t            state;
  logic [SEG_W-1:0]      seg_q;
  logic [CWF_W-1:0]      bit_cnt;
  logic [LEN_W-1:0]      out_cnt;
  logic [MAX_CODE_W-1:0] code_q;
  logic [MAX_CODE_W:0]   code_nxt;
  logic                  code_fire;
  logic                  code_full;
  logic                  emit_end;

  assign code_ready = (state == ST_COLLECT);
  assign emitting   = (state == ST_EMIT);
  assign code_fire  = code_valid && code_ready;
  assign code_nxt   = {code_q, code_bit};
  assign rd_idx     = code_nxt[MAX_CODE_W-1:0];
  assign rd_seg     = seg_q;
  assign code_full  = (bit_cnt == cur_code_w - CWF_W'(1));
  assign load       = code_fire && code_full;
  assign emit_end   = emitting && (out_cnt == cur_len - LEN_W'(1));
  assign active     = emitting || (seg_q != '0) || (bit_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_COLLECT;
      seg_q        <= '0;
      bit_cnt      <= '0;
      out_cnt      <= '0;
      code_q       <= '0;
      pattern_done <= 1'b0;
      code_err     <= 1'b0;
    end else begin
      pattern_done <= 1'b0;
      if (code_fire) begin
        if (code_full) begin
          state   <= ST_EMIT;
          bit_cnt <= '0;
          code_q  <= '0;
          out_cnt <= '0;
          if (!rd_hit) code_err <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + CWF_W'(1);
          code_q  <= rd_idx;
        end
      end
      if (emitting) begin
        if (emit_end) begin
          state <= ST_COLLECT;
          if (cur_last) begin
            seg_q        <= '0;
            pattern_done <= 1'b1;
          end else begin
            seg_q <= seg_q + SEG_W'(1);
          end
        end else begin
          out_cnt <= out_cnt + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/seg_exp_shift.sv
module seg_exp_shift #(
  parameter int MAX_LEN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               hit,
  input  logic [MAX_LEN-1:0] pat,
  input  logic               emitting,
  output logic               scan_out,
  output logic               scan_en
);
  logic [MAX_LEN-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= hit ? pat : '0;
    end else if (emitting) begin
      sreg <= {1'b0, sreg[MAX_LEN-1:1]};
    end
  end

  assign scan_en  = emitting;
  assign scan_out = emitting & sreg[0];
endmodule

// File: rtl/seg_scan_expander.sv
module seg_scan_expander
  import seg_exp_pkg::*;
#(
  parameter int NUM_SEG    = 4,
  parameter int MAX_CODE_W = 5,
  parameter int MAX_LEN    = 256,
  localparam int SEG_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int CWF_W     = $clog2(MAX_CODE_W + 1),
  localparam int LEN_W     = $clog2(MAX_LEN) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_kind,
  input  logic [SEG_W-1:0]      cfg_seg,
  input  logic [CWF_W-1:0]      cfg_code_w,
  input  logic [LEN_W-1:0]      cfg_len,
  input  logic                  cfg_last,
  input  logic [MAX_CODE_W-1:0] cfg_idx,
  input  logic [MAX_LEN-1:0]    cfg_pattern,
  input  logic                  code_valid,
  input  logic                  code_bit,
  output logic                  code_ready,
  output logic                  scan_out,
  output logic                  scan_en,
  output logic                  pattern_done,
  output logic                  code_err
);
  logic                  active;
  logic                  wr_ok;
  logic                  wr_hdr;
  logic                  wr_ent;
  logic [SEG_W-1:0]      rd_seg;
  logic [MAX_CODE_W-1:0] rd_idx;
  logic [MAX_LEN-1:0]    rd_pat;
  logic                  rd_hit;
  logic [CWF_W-1:0]      cur_code_w;
  logic [LEN_W-1:0]      cur_len;
  logic                  cur_last;
  logic                  load;
  logic                  emitting;

  assign wr_ok  = cfg_we && !active;
  assign wr_hdr = wr_ok && (cfg_kind == CFG_HEADER);
  assign wr_ent = wr_ok && (cfg_kind == CFG_ENTRY);

  seg_exp_dict #(
    .NUM_SEG(NUM_SEG), .MAX_CODE_W(MAX_CODE_W), .MAX_LEN(MAX_LEN),
    .SEG_W(SEG_W), .CWF_W(CWF_W), .LEN_W(LEN_W)
  ) i_dict (
    .clk(clk), .rst_n(rst_n),
    .wr_hdr(wr_hdr), .wr_ent(wr_ent), .wr_seg(cfg_seg),
    .wr_code_w(cfg_code_w), .wr_len(cfg_len), .wr_last(cfg_last),
    .wr_idx(cfg_idx), .wr_pat(cfg_pattern),
    .rd_seg(rd_seg), .rd_idx(rd_idx), .rd_pat(rd_pat), .rd_hit(rd_hit),
    .cur_code_w(cur_code_w), .cur_len(cur_len), .cur_last(cur_last)
  );

  seg_exp_ctrl #(
    .MAX_CODE_W(MAX_CODE_W), .SEG_W(SEG_W), .CWF_W(CWF_W), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .code_valid(code_valid), .code_bit(code_bit),
    .cur_code_w(cur_code_w), .cur_len(cur_len), .cur_last(cur_last),
    .rd_hit(rd_hit), .code_ready(code_ready),
    .rd_seg(rd_seg), .rd_idx(rd_idx), .load(load), .emitting(emitting),
    .active(active), .pattern_done(pattern_done), .code_err(code_err)
  );

  seg_exp_shift #(.MAX_LEN(MAX_LEN)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .hit(rd_hit), .pat(rd_pat),
    .emitting(emitting), .scan_out(scan_out), .scan_en(scan_en)
  );
endmodule

// File: rtl/seg_exp_chk.sv
module seg_exp_chk (
  input logic clk,
  input logic rst_n,
  input logic code_ready,
  input logic scan_en,
  input logic pattern_done,
  input logic code_err
);
  // R5
  emit_blocks_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> !code_ready);
  // R7
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_done |=> !pattern_done);
  // R7
  done_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_done |-> $past(scan_en) && !scan_en);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |=> code_err);
  // R2
  ready_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> code_ready);
endmodule

bind seg_scan_expander seg_exp_chk i_seg_exp_chk (
  .clk(clk), .rst_n(rst_n), .code_ready(code_ready), .scan_en(scan_en),
  .pattern_done(pattern_done), .code_err(code_err)
);

// File: tb/test_seg_scan_expander.sv
module test_seg_scan_expander;
  localparam int NS = 4;
  localparam int CW = 5;
  localparam int ML = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_last = 1'b0;
  logic [1:0] cfg_seg = '0;
  logic [2:0] cfg_code_w = '0;
  logic [8:0] cfg_len = '0;
  logic [4:0] cfg_idx = '0;
  logic [ML-1:0] cfg_pattern = '0;
  logic code_valid = 1'b0, code_bit = 1'b0;
  logic code_ready, scan_out, scan_en, pattern_done, code_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int  w_m [NS];
  int  len_m [NS];
  bit  last_m [NS];
  bit  hit_m [NS][32];
  bit  err_m = 1'b0;

  always #2 clk = ~clk;

  seg_scan_expander i_seg_scan_expander (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_seg(cfg_seg), .cfg_code_w(cfg_code_w), .cfg_len(cfg_len),
    .cfg_last(cfg_last), .cfg_idx(cfg_idx), .cfg_pattern(cfg_pattern),
    .code_valid(code_valid), .code_bit(code_bit), .code_ready(code_ready),
    .scan_out(scan_out), .scan_en(scan_en), .pattern_done(pattern_done),
    .code_err(code_err)
  );

  function automatic logic [ML-1:0] pat(int s, int i);
    logic [ML-1:0] p;
    for (int b = 0; b < ML; b++) p[b] = (((b * (2 * i + 3)) + s * 7 + i) % 5) < 2;
    return p;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_hdr(int s, int w, int len, bit last, bit model);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 1'b0; cfg_seg = 2'(s);
    cfg_code_w = 3'(w); cfg_len = 9'(len); cfg_last = last;
    @(negedge clk);
    cfg_we = 1'b0;
    if (model) begin
      w_m[s] = w; len_m[s] = len; last_m[s] = last || (s == NS - 1);
      for (int i = 0; i < 32; i++) hit_m[s][i] = 1'b0;
    end
  endtask

  task automatic wr_ent(int s, int i, logic [ML-1:0] p, bit model);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 1'b1; cfg_seg = 2'(s);
    cfg_idx = 5'(i); cfg_pattern = p;
    @(negedge clk);
    cfg_we = 1'b0;
    if (model) hit_m[s][i] = 1'b1;
  endtask

  task automatic run_seg(int s, int code, bit hold);
    bit exp_bit;
    for (int k = w_m[s] - 1; k >= 0; k--) begin
      @(negedge clk);
      chk(code_ready == 1'b1, "R2 ready while collecting", code_ready, 1);
      chk(scan_en == 1'b0, "R5 no scan during collect", scan_en, 0);
      code_valid = 1'b1;
      code_bit = code[k];
    end
    @(negedge clk);
    code_valid = hold;
    code_bit = 1'b1;
    if (!hit_m[s][code]) err_m = 1'b1;
    for (int j = 0; j < len_m[s]; j++) begin
      if (j > 0) @(negedge clk);
      exp_bit = hit_m[s][code] ? pat(s, code)[j] : 1'b0;
      chk(scan_en == 1'b1, "R3 scan_en during emit", scan_en, 1);
      chk(scan_out == exp_bit, hit_m[s][code] ? "R3 emitted bit" : "R6 zero fill",
          scan_out, exp_bit);
      if (hold) chk(code_ready == 1'b0, "R10 ready low in emit", code_ready, 0);
    end
    @(negedge clk);
    code_valid = 1'b0;
    chk(scan_en == 1'b0, "R4 length ends emission", scan_en, 0);
    chk(pattern_done == last_m[s], "R7 done at end of pattern", pattern_done, last_m[s]);
    chk(code_err == err_m, "R6 error flag", code_err, err_m);
  endtask

  task automatic run_pattern(int c0, int c1, int c2, int c3, bit hold);
    int codes [NS];
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    for (int s = 0; s < NS; s++) begin
      run_seg(s, codes[s], hold && (s == 0));
      if (last_m[s]) break;
    end
    @(negedge clk);
    chk(pattern_done == 1'b0, "R7 done lasts one cycle", pattern_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      w_m[s] = 1; len_m[s] = 1; last_m[s] = (s == NS - 1);
      for (int i = 0; i < 32; i++) hit_m[s][i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(code_ready == 1'b1, "R1 ready", code_ready, 1);
    chk(scan_en == 1'b0, "R1 scan_en", scan_en, 0);
    chk(pattern_done == 1'b0, "R1 done", pattern_done, 0);
    chk(code_err == 1'b0, "R1 err", code_err, 0);

    // R4 per-segment widths/lengths, three segments
    wr_hdr(0, 3, 11, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) wr_ent(0, i, pat(0, i), 1'b1);
    wr_hdr(1, 2, 10, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) wr_ent(1, i, pat(1, i), 1'b1);
    wr_hdr(2, 1, 256, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) wr_ent(2, i, pat(2, i), 1'b1);

    // R2 R3 R5 sweep every 3-bit code; R10 hold valid on one pass
    for (int c = 0; c < 8; c++) run_pattern(c, c % 3, c % 2, 0, c == 2);

    // R8 writes in the middle of a pattern are dropped
    run_seg(0, 5, 1'b0);
    wr_hdr(1, 1, 3, 1'b1, 1'b0);
    wr_ent(1, 1, ~pat(1, 1), 1'b0);
    run_seg(1, 1, 1'b0);
    run_seg(2, 1, 1'b0);
    @(negedge clk);

    // R7 end at the highest segment, length 1 segment
    wr_hdr(2, 1, 256, 1'b0, 1'b1);
    for (int i = 0; i < 2; i++) wr_ent(2, i, pat(2, i), 1'b1);
    wr_hdr(3, 2, 1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) wr_ent(3, i, pat(3, i), 1'b1);
    for (int c = 0; c < 4; c++) run_pattern(c + 4, 2 - (c % 3), 1 - (c % 2), c, 1'b0);

    // R9 header rewrite clears entries; R6 miss fills zeros and flags
    wr_hdr(0, 3, 11, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) wr_ent(0, i, pat(0, i), 1'b1);
    run_pattern(6, 0, 1, 2, 1'b0);
    chk(code_err == 1'b1, "R9 cleared entry misses", code_err, 1);
    run_pattern(3, 1, 0, 3, 1'b0);
    chk(code_err == 1'b1, "R6 error stays set", code_err, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule